// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns a single asynchronous serial line into parallel characters. It runs from a receive clock at 1, 16 or 64 times the bit rate. While idle it watches the line for a low level. In the 16x and 64x modes it then checks the line again half a bit later, so that a short glitch is rejected. After the start bit it takes one sample per bit period through the data bits, the optional parity bit and the stop bits. The finished character goes into a holding register and a ready flag is raised. The host uses that flag either as a status bit or as an interrupt request.

The host sets the character length (5 to 8 bits), parity enable and type, one or two stop bits, and the clock factor. The ready flag drops on the cycle after the host pulses the read strobe. Three sticky error flags report parity errors, framing errors and overrun. All three stay set until the host pulses the error-clear input.

The controller is a five-state machine. The states and their transitions are:
- IDLE to START when the line is low in the 16x or 64x modes.
- IDLE to DATA when the line is low in 1x mode.
- START to IDLE when the line is high again at the half-bit recheck.
- START to DATA when the line is still low at the recheck.
- DATA to PARITY after the last data bit when parity is enabled, and DATA to STOP when it is not.
- PARITY to STOP.
- STOP back to STOP once after the first stop bit when two stop bits are selected.
- STOP to IDLE with the character delivered.

Top module: `async_char_rx`

## Requirements
- R1: While idle with the line high, the receiver stays idle and delivers no character.
- R2: In the 16x and 64x modes, a low level is rechecked 8 or 32 receive clocks later. If the line is high at the recheck, the event is dropped and no character is delivered.
- R3: In 1x mode a low level is accepted as a start bit at once, and each following bit is sampled on the next receive clock.
- R4: Data bits are taken least significant bit first, one sample per full bit period (16 or 64 clocks) counted from the midpoint of the start bit.
- R5: `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits of `rx_data` above the character length read zero.
- R6: With `cfg_par_en` high, one parity bit follows the data bits. `cfg_par_odd`=1 selects odd parity and 0 selects even parity, both counted over the data bits plus the parity bit. A mismatch sets `par_err`.
- R7: `cfg_stop2` selects one stop bit (0) or two (1). A stop bit sampled low sets `frame_err`.
- R8: `rx_ready` rises one cycle after a character completes. It falls on the clock edge at which `rd_strobe` is seen high.
- R9: If a character completes while `rx_ready` is still high, `overrun_err` is set and `rx_data` takes the new character.
- R10: `par_err`, `frame_err` and `overrun_err` stay set until `err_clr` is pulsed, which clears all three.
- R11: `cfg_factor` selects the clock factor: code 0 is 1x, code 1 is 16x, and codes 2 and 3 are 64x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_factor | input | 2 | Clock factor: 0 is 1x, 1 is 16x, 2 and 3 are 64x |
| rd_strobe | input | 1 | Host reads the character and clears ready |
| err_clr | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Last character received |
| rx_ready | output | 1 | A character is waiting to be read |
| par_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun |

## Verification
Several properties are checked on every cycle:
- An idle state with the line high stays idle.
- A high line at the start recheck returns the machine to idle.
- In 1x mode a low line goes straight to data sampling.
- The ready flag sets when a character completes and clears on a read strobe.
- An overrun is flagged when a character completes while ready is still high.
- Error-clear empties all three error flags.

Other behaviour can only be shown by the bench's scenarios. These include the bit order, the masking of high bits for short characters, the parity sense, the sample timing at each clock factor, and the way a glitch leaves no trace in the outputs.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int unsigned DIV_MID  = 16;
    localparam int unsigned DIV_HIGH = 64;
    localparam int unsigned CNT_W    = $clog2(DIV_HIGH);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Reload value for one full bit period, minus one.
    function automatic logic [CNT_W-1:0] full_m1(input logic [1:0] factor);
        case (factor)
            2'd0:    full_m1 = '0;
            2'd1:    full_m1 = CNT_W'(DIV_MID - 1);
            default: full_m1 = CNT_W'(DIV_HIGH - 1);
        endcase
    endfunction

    // Reload value for half a bit period, minus one (not used in 1x mode).
    function automatic logic [CNT_W-1:0] half_m1(input logic [1:0] factor);
        case (factor)
            2'd0:    half_m1 = '0;
            2'd1:    half_m1 = CNT_W'(DIV_MID / 2 - 1);
            default: half_m1 = CNT_W'(DIV_HIGH / 2 - 1);
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int unsigned CW = async_rx_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          tick
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import async_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              tick,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic [1:0]        cfg_factor,
    output logic              load,
    output logic [CW-1:0]     load_val,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_par_bad,
    output logic              done_frame_bad
);
    localparam int unsigned IDX_W    = $clog2(DATA_W);
    localparam int unsigned LEN_BASE = 5;

    rx_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              stop_idx_q;
    logic              par_bad_q;
    logic              frm_bad_q;
    logic [IDX_W-1:0]  last_idx;

    assign last_idx = IDX_W'(cfg_len) + IDX_W'(LEN_BASE - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = full_m1(cfg_factor);
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!line) begin
                    load = 1'b1;
                    if (cfg_factor == 2'd0) begin
                        state_d = ST_DATA;
                    end else begin
                        load_val = half_m1(cfg_factor);
                        state_d  = ST_START;
                    end
                end
            end
            ST_START: begin
                if (tick) begin
                    load    = 1'b1;
                    state_d = line ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    load = 1'b1;
                    if (bit_idx_q == last_idx)
                        state_d = cfg_par_en ? ST_PAR : ST_STOP;
                end
            end
            ST_PAR: begin
                if (tick) begin
                    load    = 1'b1;
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (cfg_stop2 && !stop_idx_q) begin
                        load = 1'b1;
                    end else begin
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Character datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
            par_bad_q  <= 1'b0;
            frm_bad_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!line) begin
                        data_q     <= '0;
                        bit_idx_q  <= '0;
                        stop_idx_q <= 1'b0;
                        par_bad_q  <= 1'b0;
                        frm_bad_q  <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        data_q[bit_idx_q] <= line;
                        bit_idx_q         <= bit_idx_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (tick) par_bad_q <= (^data_q) ^ line ^ cfg_par_odd;
                end
                ST_STOP: begin
                    if (tick) begin
                        frm_bad_q  <= frm_bad_q | ~line;
                        stop_idx_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done_data      = data_q;
    assign done_par_bad   = par_bad_q;
    assign done_frame_bad = frm_bad_q | ~line;

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && line) |=> (state_q == ST_IDLE));

    p_glitch_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick && line) |=> (state_q == ST_IDLE));

    p_x1_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !line && cfg_factor == 2'd0) |=> (state_q == ST_DATA));
endmodule

// File: rtl/rx_result_regs.sv
module rx_result_regs #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] done_data,
    input  logic              done_par_bad,
    input  logic              done_frame_bad,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frame_err,
    output logic              overrun_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            par_err     <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            if (done) rx_data <= done_data;
            rx_ready    <= done | (rx_ready & ~rd_strobe);
            par_err     <= (par_err & ~err_clr) | (done & done_par_bad);
            frame_err   <= (frame_err & ~err_clr) | (done & done_frame_bad);
            overrun_err <= (overrun_err & ~err_clr) | (done & rx_ready);
        end
    end

    p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready);

    p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rd_strobe && !done) |=> !rx_ready);

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_ready) |=> overrun_err);

    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !done) |=> (!par_err && !frame_err && !overrun_err));
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import async_rx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic [1:0]        cfg_factor,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frame_err,
    output logic              overrun_err
);
    logic             line_s;
    logic             tick;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             done;
    logic [DATA_W-1:0] done_data;
    logic             done_par_bad;
    logic             done_frame_bad;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (line_s)
    );

    rx_bit_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick)
    );

    rx_frame_fsm #(.DATA_W(DATA_W), .CW(CNT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .line           (line_s),
        .tick           (tick),
        .cfg_len        (cfg_len),
        .cfg_par_en     (cfg_par_en),
        .cfg_par_odd    (cfg_par_odd),
        .cfg_stop2      (cfg_stop2),
        .cfg_factor     (cfg_factor),
        .load           (load),
        .load_val       (load_val),
        .done           (done),
        .done_data      (done_data),
        .done_par_bad   (done_par_bad),
        .done_frame_bad (done_frame_bad)
    );

    rx_result_regs #(.DATA_W(DATA_W)) u_result (
        .clk            (clk),
        .rst_n          (rst_n),
        .done           (done),
        .done_data      (done_data),
        .done_par_bad   (done_par_bad),
        .done_frame_bad (done_frame_bad),
        .rd_strobe      (rd_strobe),
        .err_clr        (err_clr),
        .rx_data        (rx_data),
        .rx_ready       (rx_ready),
        .par_err        (par_err),
        .frame_err      (frame_err),
        .overrun_err    (overrun_err)
    );
endmodule

// File: tb/async_char_rx_tb.sv
module async_char_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic [1:0] cfg_factor = 2'd1;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, par_err, frame_err, overrun_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    async_char_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_factor(cfg_factor),
        .rd_strobe(rd_strobe), .err_clr(err_clr),
        .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
        .frame_err(frame_err), .overrun_err(overrun_err)
    );

    function automatic int div_of(input logic [1:0] f);
        return (f == 2'd0) ? 1 : (f == 2'd1) ? 16 : 64;
    endfunction

    function automatic logic [7:0] mask_of(input logic [7:0] d, input logic [1:0] len);
        return d & (8'hFF >> (3 - len));
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [1:0] len, input logic odd);
        return (^mask_of(d, len)) ^ odd;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int div);
        repeat (div) @(negedge clk) rxd = b;
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        int div = div_of(cfg_factor);
        drive_bit(1'b0, div);
        for (int i = 0; i <= 4 + int'(cfg_len); i++) drive_bit(d[i], div);
        if (cfg_par_en) drive_bit(par_of(d, cfg_len, cfg_par_odd) ^ bad_par, div);
        drive_bit(~bad_stop, div);
        if (cfg_stop2) drive_bit(1'b1, div);
        repeat (2 * div + 6) @(negedge clk) rxd = 1'b1;
    endtask

    task automatic host_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic host_clear();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    // Full frame round trip with expected results.
    task automatic frame_check(input string req, input logic [7:0] d,
                               input logic bad_par, input logic bad_stop);
        send(d, bad_par, bad_stop);
        check(req, "ready", {31'd0, rx_ready}, 32'd1);
        check(req, "data", {24'd0, rx_data}, {24'd0, mask_of(d, cfg_len)});
        check(req, "par_err", {31'd0, par_err}, {31'd0, bad_par & cfg_par_en});
        check(req, "frame_err", {31'd0, frame_err}, {31'd0, bad_stop});
        check(req, "overrun", {31'd0, overrun_err}, 32'd0);
        host_read();
        check("R8", "ready after read", {31'd0, rx_ready}, 32'd0);
        host_clear();
        check("R10", "flags after clear", {29'd0, par_err, frame_err, overrun_err}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "reset ready", {31'd0, rx_ready}, 32'd0);
        check("R10", "reset flags", {29'd0, par_err, frame_err, overrun_err}, 32'd0);
        check("R5", "reset data", {24'd0, rx_data}, 32'd0);

        // R1: idle line stays idle
        repeat (300) @(negedge clk);
        check("R1", "idle ready", {31'd0, rx_ready}, 32'd0);

        // R2: glitches in 16x and 64x modes are dropped
        cfg_factor = 2'd1;
        repeat (5) @(negedge clk) rxd = 1'b0;
        repeat (200) @(negedge clk) rxd = 1'b1;
        check("R2", "glitch x16 ready", {31'd0, rx_ready}, 32'd0);
        cfg_factor = 2'd2;
        repeat (20) @(negedge clk) rxd = 1'b0;
        repeat (800) @(negedge clk) rxd = 1'b1;
        check("R2", "glitch x64 ready", {31'd0, rx_ready}, 32'd0);
        check("R2", "glitch flags", {29'd0, par_err, frame_err, overrun_err}, 32'd0);

        // R4: plain 8-bit character in 16x mode
        cfg_factor = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        frame_check("R4", 8'hA5, 1'b0, 1'b0);

        // R3: 1x mode
        cfg_factor = 2'd0;
        frame_check("R3", 8'h3C, 1'b0, 1'b0);

        // R5: short character masks high bits
        cfg_factor = 2'd1; cfg_len = 2'd0;
        frame_check("R5", 8'hFF, 1'b0, 1'b0);

        // R6: odd and even parity, good and bad
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        frame_check("R6", 8'h47, 1'b0, 1'b0);
        frame_check("R6", 8'h47, 1'b1, 1'b0);
        cfg_par_odd = 1'b0;
        frame_check("R6", 8'h12, 1'b1, 1'b0);

        // R7: framing error with one and two stop bits
        cfg_par_en = 1'b0;
        frame_check("R7", 8'h55, 1'b0, 1'b1);
        cfg_stop2 = 1'b1;
        frame_check("R7", 8'h66, 1'b0, 1'b1);
        frame_check("R7", 8'h0F, 1'b0, 1'b0);

        // R11: code 3 behaves as 64x
        cfg_factor = 2'd3; cfg_len = 2'd3; cfg_stop2 = 1'b0;
        frame_check("R11", 8'hC3, 1'b0, 1'b0);

        // R9: overrun when the first character is not read
        cfg_factor = 2'd1;
        send(8'h11, 1'b0, 1'b0);
        send(8'h22, 1'b0, 1'b0);
        check("R9", "overrun", {31'd0, overrun_err}, 32'd1);
        check("R9", "newest data", {24'd0, rx_data}, 32'h22);
        host_read();
        host_clear();
        check("R10", "overrun cleared", {31'd0, overrun_err}, 32'd0);

        // Random characters across all modes
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d;
            logic bp, bs;
            r = $urandom;
            cfg_factor  = 2'(r % 3);
            cfg_len     = r[3:2];
            cfg_par_en  = r[4];
            cfg_par_odd = r[5];
            cfg_stop2   = r[6];
            d  = r[15:8];
            bp = (r[19:16] == 4'd0);
            bs = (r[23:20] == 4'd0);
            frame_check("R4", d, bp, bs);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule